// File: doc/BRIEF.md
# Paddle Game State Engine

This block keeps the full state of a two-player paddle-and-ball game and advances it by one game step each time the update strobe `tick` is seen high on a rising clock edge. Each player turns a knob whose 10-bit sample is mapped to the vertical position of that player's paddle. On every step the ball is moved by its velocity and then tested against the paddles and the upper and lower walls. A miss awards a point to the opponent, re-serves the ball from the centre, and starts a pause. When one side reaches the winning score, a longer pause follows and both scores are cleared.

The ball's position and velocity are held as signed fixed-point numbers with four fractional bits, so slow diagonal motion stays smooth. The outputs are integer pixel coordinates for a display pipeline. A paddle hit speeds the ball up by a quarter pixel per step. How far the paddle moved over the last two steps bends the vertical velocity. A match controller with three states sequences play and the two pauses:

- `ST_PLAY`: the ball moves on each tick.
- `ST_POINT_WAIT`: the ball is frozen after a point.
- `ST_MATCH_WAIT`: the ball is frozen after a winning point.

The transitions are:

- *miss*: `ST_PLAY` to `ST_POINT_WAIT`.
- *resume*: `ST_POINT_WAIT` to `ST_PLAY` when the pause ends and nobody has won.
- *match over*: `ST_POINT_WAIT` to `ST_MATCH_WAIT` when the pause ends and a score equals the winning score.
- *new match*: `ST_MATCH_WAIT` to `ST_PLAY`, which clears both scores.

Top module: `pong_engine`

## Requirements
- R1: While `rst_n` is low, and after it rises with no tick yet, `ball_x` = 328 and `ball_y` = 286. Both scores are 0 and the state is `ST_PLAY`. Both velocity components are +16 (one pixel per step), and both stored paddle histories equal 78.
- R2: One clock after a knob sample `s` is presented, the paddle's vertical output equals 78 + ((s * 300) >> 10). It therefore always lies in the range 78 to 377.
- R3: On a tick in `ST_PLAY`, each velocity component is added to the fixed-point position. `ball_x` and `ball_y` are the fixed-point values shifted right arithmetically by 4. Collision tests use this new position.
- R4: With the new integer y at or below 78 and vy negative, or at or above 462 and vy positive, vy is negated. The wall test uses vy after any paddle adjustment in the same step.
- R5: The left paddle is tested when the new integer x is at most 5 and vx is negative. It is a hit when y + 16 is at least the paddle y and y is at most the paddle y + 100. A hit sets vx to 4 − vx.
- R6: The right paddle is tested when the new integer x is at least 619 and vx is positive, using the same overlap rule as R5. A hit sets vx to −vx − 4.
- R7: A paddle hit also adds 4 × d to vy. Here d is that paddle's y at this step minus its y as recorded two steps earlier. The history advances only on steps taken in `ST_PLAY`.
- R8: A miss on the left adds one point to the right score (`score_r`), and a miss on the right adds one point to `score_l`. Either miss places the ball back at (328, 286) with vy = +16. vx is +16, or −16 when `score_l` was the one that increased.
- R9: After a point, the next 32 ticks leave the ball, scores and paddle history unchanged. The tick after them moves the ball again.
- R10: If a score equals 5 when the 32-tick pause ends, a further 128 ticks pass with the ball frozen. Both scores then return to 0 and play resumes on the following tick.
- R11: Without a tick the ball position, the scores and the paddle history do not change, whatever the knob samples do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Game step strobe, one clock wide |
| pad_l_sample | input | 10 | Left knob sample |
| pad_r_sample | input | 10 | Right knob sample |
| ball_x | output | 12 | Signed integer ball column |
| ball_y | output | 12 | Signed integer ball row |
| pad_l_y | output | 10 | Left paddle top row |
| pad_r_y | output | 10 | Right paddle top row |
| score_l | output | 3 | Left player score |
| score_r | output | 3 | Right player score |

## Verification
The bench plays long rallies with paddles that chase the ball at a limited rate, so paddle hits happen with small non-zero displacements. A design that measured displacement over one step instead of two, or that kept updating history during pauses, would leave vy off after the next hit. One paddle is then parked away from the ball until a full match is lost, which exercises the serve direction, the exact 32- and 128-tick pause lengths and the score clear. An off-by-one pause counter, or a serve that always goes right, shows up as a position mismatch on a specific tick. Random knob bursts provoke large velocity bends and wall hits, where testing the wall before the paddle adjustment changes the vertical sign. Idle stretches without a tick check that the knob samples alone never disturb the game.

// File: rtl/pong_pkg.sv
package pong_pkg;
    // Fixed-point ball state: POS_W bits total, FRAC fractional bits.
    parameter int POS_W = 16;
    parameter int FRAC  = 4;
    parameter int PIX_W = POS_W - FRAC;

    typedef struct packed {
        logic signed [POS_W-1:0] x;
        logic signed [POS_W-1:0] y;
        logic signed [POS_W-1:0] vx;
        logic signed [POS_W-1:0] vy;
    } ball_fx_t;

    typedef enum logic [1:0] {
        ST_PLAY       = 2'd0,
        ST_POINT_WAIT = 2'd1,
        ST_MATCH_WAIT = 2'd2
    } match_state_t;
endpackage

// File: rtl/pong_paddle_track.sv
module pong_paddle_track #(
    parameter int SAMPLE_W   = 10,
    parameter int Y_W        = 10,
    parameter int FIELD_Y0   = 78,
    parameter int TRAVEL     = 300,
    parameter int HIST_DEPTH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                advance,
    output logic [Y_W-1:0]      y,
    output logic signed [Y_W:0] delta
);
    localparam int PROD_W = SAMPLE_W + $clog2(TRAVEL + 1);

    logic [PROD_W-1:0]                 prod;
    logic [Y_W-1:0]                    y_new;
    logic [HIST_DEPTH-1:0][Y_W-1:0]    hist;

    assign prod  = PROD_W'(sample) * PROD_W'(TRAVEL);
    assign y_new = Y_W'(prod >> SAMPLE_W) + Y_W'(FIELD_Y0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y <= Y_W'(FIELD_Y0);
        end else begin
            y <= y_new;
        end
    end

    // History of paddle rows taken on game steps only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= {HIST_DEPTH{Y_W'(FIELD_Y0)}};
        end else if (advance) begin
            for (int i = HIST_DEPTH - 1; i > 0; i--) begin
                hist[i] <= hist[i-1];
            end
            hist[0] <= y;
        end
    end

    assign delta = $signed({1'b0, y}) - $signed({1'b0, hist[HIST_DEPTH-1]});

    assert_paddle_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (y >= Y_W'(FIELD_Y0)) && (y < Y_W'(FIELD_Y0 + TRAVEL)));

    assert_hist_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(hist));
endmodule

// File: rtl/pong_ball_step.sv
module pong_ball_step
    import pong_pkg::*;
#(
    parameter int Y_W        = 10,
    parameter int FIELD_W    = 640,
    parameter int FIELD_H    = 400,
    parameter int FIELD_Y0   = 78,
    parameter int PAD_W      = 5,
    parameter int PAD_H      = 100,
    parameter int BALL_SZ    = 16,
    parameter int KICK       = 4,
    parameter int BEND_SHIFT = 2
) (
    input  ball_fx_t             cur,
    input  logic [Y_W-1:0]       pad_l_y,
    input  logic [Y_W-1:0]       pad_r_y,
    input  logic signed [Y_W:0]  delta_l,
    input  logic signed [Y_W:0]  delta_r,
    output ball_fx_t             nxt,
    output logic                 hit_l,
    output logic                 hit_r,
    output logic                 miss_l,
    output logic                 miss_r
);
    localparam logic signed [POS_W-1:0] L_LIMIT   = POS_W'(PAD_W);
    localparam logic signed [POS_W-1:0] R_LIMIT   = POS_W'(FIELD_W - PAD_W - BALL_SZ);
    localparam logic signed [POS_W-1:0] TOP_LIMIT = POS_W'(FIELD_Y0);
    localparam logic signed [POS_W-1:0] BOT_LIMIT = POS_W'(FIELD_Y0 + FIELD_H - BALL_SZ);
    localparam logic signed [POS_W-1:0] S_BALL    = POS_W'(BALL_SZ);
    localparam logic signed [POS_W-1:0] S_PADH    = POS_W'(PAD_H);
    localparam logic signed [POS_W-1:0] S_KICK    = POS_W'(KICK);

    function automatic logic covers(input logic signed [POS_W-1:0] by,
                                    input logic [Y_W-1:0] py);
        logic signed [POS_W-1:0] p;
        p = $signed({{(POS_W - Y_W){1'b0}}, py});
        return (by + S_BALL >= p) && (by <= p + S_PADH);
    endfunction

    logic signed [POS_W-1:0] mx, my, ix, iy, vx1, vy1, bend_l, bend_r;
    logic                    in_l, in_r, vx_neg, vx_pos;

    always_comb begin
        mx     = cur.x + cur.vx;
        my     = cur.y + cur.vy;
        ix     = mx >>> FRAC;
        iy     = my >>> FRAC;
        vx_neg = cur.vx[POS_W-1];
        vx_pos = !cur.vx[POS_W-1] && (cur.vx != '0);
        in_l   = (ix <= L_LIMIT) && vx_neg;
        in_r   = (ix >= R_LIMIT) && vx_pos;
        hit_l  = in_l && covers(iy, pad_l_y);
        hit_r  = in_r && covers(iy, pad_r_y);
        miss_l = in_l && !hit_l;
        miss_r = in_r && !hit_r;
        bend_l = POS_W'(delta_l) <<< BEND_SHIFT;
        bend_r = POS_W'(delta_r) <<< BEND_SHIFT;

        vx1 = cur.vx;
        vy1 = cur.vy;
        if (hit_l) begin
            vx1 = S_KICK - cur.vx;
            vy1 = cur.vy + bend_l;
        end else if (hit_r) begin
            vx1 = -cur.vx - S_KICK;
            vy1 = cur.vy + bend_r;
        end

        if ((iy <= TOP_LIMIT) && vy1[POS_W-1]) begin
            vy1 = -vy1;
        end else if ((iy >= BOT_LIMIT) && !vy1[POS_W-1] && (vy1 != '0)) begin
            vy1 = -vy1;
        end

        nxt.x  = mx;
        nxt.y  = my;
        nxt.vx = vx1;
        nxt.vy = vy1;
    end
endmodule

// File: rtl/pong_match_fsm.sv
module pong_match_fsm
    import pong_pkg::*;
#(
    parameter int WIN_SCORE   = 5,
    parameter int POINT_PAUSE = 32,
    parameter int MATCH_PAUSE = 128,
    parameter int SCORE_W     = $clog2(WIN_SCORE + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               miss_l,
    input  logic               miss_r,
    output logic               step_en,
    output logic [SCORE_W-1:0] score_l,
    output logic [SCORE_W-1:0] score_r
);
    localparam int LONGEST = (POINT_PAUSE > MATCH_PAUSE) ? POINT_PAUSE : MATCH_PAUSE;
    localparam int CNT_W   = $clog2(LONGEST + 1);

    match_state_t      state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              match_over, point_done, match_done, missed;

    assign match_over = (score_l == SCORE_W'(WIN_SCORE)) || (score_r == SCORE_W'(WIN_SCORE));
    assign point_done = tick && (cnt_q == CNT_W'(POINT_PAUSE - 1));
    assign match_done = tick && (cnt_q == CNT_W'(MATCH_PAUSE - 1));
    assign missed     = miss_l || miss_r;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PLAY:       if (tick && missed) state_d = ST_POINT_WAIT;
            ST_POINT_WAIT: if (point_done) state_d = match_over ? ST_MATCH_WAIT : ST_PLAY;
            ST_MATCH_WAIT: if (match_done) state_d = ST_PLAY;
            default:       state_d = ST_PLAY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PLAY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        step_en = (state_q == ST_PLAY) && tick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            score_l <= '0;
            score_r <= '0;
        end else begin
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (tick && (state_q != ST_PLAY)) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (step_en && miss_l) score_r <= score_r + 1'b1;
            if (step_en && miss_r) score_l <= score_l + 1'b1;
            if ((state_q == ST_MATCH_WAIT) && match_done) begin
                score_l <= '0;
                score_r <= '0;
            end
        end
    end

    assert_score_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (score_l <= SCORE_W'(WIN_SCORE)) && (score_r <= SCORE_W'(WIN_SCORE)));

    assert_match_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MATCH_WAIT) |-> match_over);

    assert_score_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (score_l != $past(score_l)) |-> ((score_l == $past(score_l) + 1'b1) || (score_l == '0)));

    assert_pause_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(LONGEST));
endmodule

// File: rtl/pong_engine.sv
module pong_engine
    import pong_pkg::*;
#(
    parameter int SAMPLE_W    = 10,
    parameter int Y_W         = 10,
    parameter int FIELD_W     = 640,
    parameter int FIELD_H     = 400,
    parameter int FIELD_Y0    = 78,
    parameter int PAD_W       = 5,
    parameter int PAD_H       = 100,
    parameter int BALL_SZ     = 16,
    parameter int KICK        = 4,
    parameter int BEND_SHIFT  = 2,
    parameter int HIST_DEPTH  = 2,
    parameter int WIN_SCORE   = 5,
    parameter int POINT_PAUSE = 32,
    parameter int MATCH_PAUSE = 128,
    parameter int SCORE_W     = $clog2(WIN_SCORE + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic [SAMPLE_W-1:0]     pad_l_sample,
    input  logic [SAMPLE_W-1:0]     pad_r_sample,
    output logic signed [PIX_W-1:0] ball_x,
    output logic signed [PIX_W-1:0] ball_y,
    output logic [Y_W-1:0]          pad_l_y,
    output logic [Y_W-1:0]          pad_r_y,
    output logic [SCORE_W-1:0]      score_l,
    output logic [SCORE_W-1:0]      score_r
);
    localparam logic signed [POS_W-1:0] SERVE_X = POS_W'(((FIELD_W + BALL_SZ) / 2) << FRAC);
    localparam logic signed [POS_W-1:0] SERVE_Y = POS_W'((FIELD_Y0 + (FIELD_H + BALL_SZ) / 2) << FRAC);
    localparam logic signed [POS_W-1:0] ONE_PX  = POS_W'(1 << FRAC);

    logic [SAMPLE_W-1:0]     samples [2];
    logic [Y_W-1:0]          pad_y   [2];
    logic signed [Y_W:0]     delta   [2];
    logic                    step_en, hit_l, hit_r, miss_l, miss_r;
    ball_fx_t                ball_q, ball_nxt;

    assign samples[0] = pad_l_sample;
    assign samples[1] = pad_r_sample;

    for (genvar g = 0; g < 2; g++) begin : g_paddle
        pong_paddle_track #(
            .SAMPLE_W(SAMPLE_W), .Y_W(Y_W), .FIELD_Y0(FIELD_Y0),
            .TRAVEL(FIELD_H - PAD_H), .HIST_DEPTH(HIST_DEPTH)
        ) u_track (
            .clk(clk), .rst_n(rst_n), .sample(samples[g]), .advance(step_en),
            .y(pad_y[g]), .delta(delta[g])
        );
    end

    pong_ball_step #(
        .Y_W(Y_W), .FIELD_W(FIELD_W), .FIELD_H(FIELD_H), .FIELD_Y0(FIELD_Y0),
        .PAD_W(PAD_W), .PAD_H(PAD_H), .BALL_SZ(BALL_SZ), .KICK(KICK),
        .BEND_SHIFT(BEND_SHIFT)
    ) u_step (
        .cur(ball_q), .pad_l_y(pad_y[0]), .pad_r_y(pad_y[1]),
        .delta_l(delta[0]), .delta_r(delta[1]), .nxt(ball_nxt),
        .hit_l(hit_l), .hit_r(hit_r), .miss_l(miss_l), .miss_r(miss_r)
    );

    pong_match_fsm #(
        .WIN_SCORE(WIN_SCORE), .POINT_PAUSE(POINT_PAUSE),
        .MATCH_PAUSE(MATCH_PAUSE), .SCORE_W(SCORE_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .miss_l(miss_l), .miss_r(miss_r),
        .step_en(step_en), .score_l(score_l), .score_r(score_r)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ball_q <= '{x: SERVE_X, y: SERVE_Y, vx: ONE_PX, vy: ONE_PX};
        end else if (step_en) begin
            if (miss_l || miss_r) begin
                ball_q <= '{x: SERVE_X, y: SERVE_Y, vx: (miss_r ? -ONE_PX : ONE_PX), vy: ONE_PX};
            end else begin
                ball_q <= ball_nxt;
            end
        end
    end

    assign ball_x  = PIX_W'(ball_q.x >>> FRAC);
    assign ball_y  = PIX_W'(ball_q.y >>> FRAC);
    assign pad_l_y = pad_y[0];
    assign pad_r_y = pad_y[1];

    assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(ball_q));

    assert_left_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && hit_l) |=> (!ball_q.vx[POS_W-1] && (ball_q.vx != '0)));

    assert_right_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && hit_r) |=> ball_q.vx[POS_W-1]);

    assert_serve_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && miss_r) |=> ((ball_q.vx == -ONE_PX) && (ball_q.x == SERVE_X) && (ball_q.y == SERVE_Y)));
endmodule

// File: tb/pong_engine_tb_top.sv
module pong_engine_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [9:0]        pad_l_sample = '0;
    logic [9:0]        pad_r_sample = '0;
    logic signed [11:0] ball_x, ball_y;
    logic [9:0]        pad_l_y, pad_r_y;
    logic [2:0]        score_l, score_r;

    int n_checks = 0;
    int n_fail   = 0;

    // model state
    int m_bx, m_by, m_vx, m_vy, m_sl, m_sr, m_state, m_cnt;
    int m_hl0, m_hl1, m_hr0, m_hr1;
    string m_tag;
    int cov_wall, cov_hl, cov_hr, cov_bend, cov_pt_l, cov_pt_r, cov_pw, cov_mw_done;
    int sl, sr;

    always #5 clk = ~clk;

    pong_engine dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .pad_l_sample(pad_l_sample), .pad_r_sample(pad_r_sample),
        .ball_x(ball_x), .ball_y(ball_y), .pad_l_y(pad_l_y), .pad_r_y(pad_r_y),
        .score_l(score_l), .score_r(score_r)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int pad_of(input int s);
        return ((s * 300) >> 10) + 78;
    endfunction

    function automatic void model_reset();
        m_bx = 328 * 16; m_by = 286 * 16; m_vx = 16; m_vy = 16;
        m_sl = 0; m_sr = 0; m_state = 0; m_cnt = 0;
        m_hl0 = 78; m_hl1 = 78; m_hr0 = 78; m_hr1 = 78;
    endfunction

    function automatic void serve(input int dir);
        m_bx = 328 * 16; m_by = 286 * 16; m_vx = 16 * dir; m_vy = 16;
        m_state = 1; m_cnt = 0;
    endfunction

    function automatic void model_tick(input int pl, input int pr);
        int dl, dr, mx, my, ix, iy, nvx, nvy;
        m_tag = "R3";
        if (m_state == 0) begin
            dl = pl - m_hl1; dr = pr - m_hr1;
            m_hl1 = m_hl0; m_hl0 = pl; m_hr1 = m_hr0; m_hr0 = pr;
            mx = m_bx + m_vx; my = m_by + m_vy;
            ix = mx >>> 4; iy = my >>> 4;
            nvx = m_vx; nvy = m_vy;
            if (ix <= 5 && m_vx < 0) begin
                if (iy + 16 >= pl && iy <= pl + 100) begin
                    nvx = 4 - m_vx; nvy = m_vy + 4 * dl; cov_hl++;
                    m_tag = "R5";
                    if (dl != 0) begin m_tag = "R5 R7"; cov_bend++; end
                end else begin
                    m_sr++; cov_pt_r++; serve(1); m_tag = "R8"; return;
                end
            end else if (ix >= 619 && m_vx > 0) begin
                if (iy + 16 >= pr && iy <= pr + 100) begin
                    nvx = -m_vx - 4; nvy = m_vy + 4 * dr; cov_hr++;
                    m_tag = "R6";
                    if (dr != 0) begin m_tag = "R6 R7"; cov_bend++; end
                end else begin
                    m_sl++; cov_pt_l++; serve(-1); m_tag = "R8"; return;
                end
            end
            if ((iy <= 78 && nvy < 0) || (iy >= 462 && nvy > 0)) begin
                nvy = -nvy; cov_wall++;
                if (m_tag == "R3") m_tag = "R4";
            end
            m_bx = mx; m_by = my; m_vx = nvx; m_vy = nvy;
        end else if (m_state == 1) begin
            m_tag = "R9"; cov_pw++;
            if (m_cnt == 31) begin
                m_cnt = 0;
                m_state = (m_sl == 5 || m_sr == 5) ? 2 : 0;
            end else m_cnt++;
        end else begin
            m_tag = "R10";
            if (m_cnt == 127) begin
                m_sl = 0; m_sr = 0; m_state = 0; m_cnt = 0; cov_mw_done++;
            end else m_cnt++;
        end
    endfunction

    task automatic compare_all();
        check(ball_x == 12'(m_bx >>> 4), m_tag, "ball_x", int'(ball_x), m_bx >>> 4);
        check(ball_y == 12'(m_by >>> 4), m_tag, "ball_y", int'(ball_y), m_by >>> 4);
        check(score_l == 3'(m_sl) && score_r == 3'(m_sr), (m_state == 2) ? "R10" : "R8",
              "scores l*8+r", int'(score_l) * 8 + int'(score_r), m_sl * 8 + m_sr);
        check(pad_l_y == 10'(pad_of(sl)) && pad_r_y == 10'(pad_of(sr)), "R2",
              "paddle rows l*1024+r", int'(pad_l_y) * 1024 + int'(pad_r_y),
              pad_of(sl) * 1024 + pad_of(sr));
    endtask

    task automatic do_tick(input int a, input int b);
        @(negedge clk);
        sl = a; sr = b;
        pad_l_sample = 10'(a); pad_r_sample = 10'(b);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_tick(pad_of(a), pad_of(b));
        compare_all();
    endtask

    function automatic int track(input int cur, input int lim);
        int want, target;
        target = (m_by >>> 4) + 8 - 50;
        want = ((target - 78) * 1024) / 300;
        if (want < 0) want = 0;
        if (want > 1023) want = 1023;
        if (want > cur + lim) want = cur + lim;
        if (want < cur - lim) want = cur - lim;
        return want;
    endfunction

    function automatic int park(input int dummy);
        return ((m_by >>> 4) > 230) ? 0 : 1023 + dummy * 0;
    endfunction

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0;
        sl = 0; sr = 0; pad_l_sample = '0; pad_r_sample = '0;
        repeat (3) @(negedge clk);
        model_reset();
        check(ball_x == 12'sd328 && ball_y == 12'sd286, "R1", "reset ball x*1024+y",
              int'(ball_x) * 1024 + int'(ball_y), 328 * 1024 + 286);
        check(score_l == 0 && score_r == 0, "R1", "reset scores",
              int'(score_l) * 8 + int'(score_r), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ball_x == 12'sd328 && ball_y == 12'sd286, "R1", "ball after release",
              int'(ball_x) * 1024 + int'(ball_y), 328 * 1024 + 286);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #1_500_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int dummy;
        dummy = $urandom(20240611);
        cov_wall = 0; cov_hl = 0; cov_hr = 0; cov_bend = 0;
        cov_pt_l = 0; cov_pt_r = 0; cov_pw = 0; cov_mw_done = 0;
        reset_dut();

        // R1: first step from serve
        do_tick(0, 0);
        check(ball_x == 12'sd329 && ball_y == 12'sd287, "R1", "first step x*1024+y",
              int'(ball_x) * 1024 + int'(ball_y), 329 * 1024 + 287);

        // R2 directed mapping corners
        begin
            int vals[4] = '{1023, 512, 4, 1};
            int exps[4] = '{377, 228, 79, 78};
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                pad_l_sample = 10'(vals[i]); pad_r_sample = 10'(1023 - vals[i]);
                @(negedge clk);
                check(pad_l_y == 10'(exps[i]), "R2", "left paddle row", int'(pad_l_y), exps[i]);
                check(pad_r_y == 10'(pad_of(1023 - vals[i])), "R2", "right paddle row",
                      int'(pad_r_y), pad_of(1023 - vals[i]));
            end
        end

        // R11: no tick, knobs wiggle, state must hold
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            pad_l_sample = 10'($urandom % 1024); pad_r_sample = 10'($urandom % 1024);
            check(ball_x == 12'(m_bx >>> 4) && ball_y == 12'(m_by >>> 4), "R11",
                  "ball idle x*1024+y", int'(ball_x) * 1024 + int'(ball_y),
                  (m_bx >>> 4) * 1024 + (m_by >>> 4));
        end
        sl = 0; sr = 0;

        // rally: both chase the ball at a limited rate
        for (int i = 0; i < 1500; i++) begin
            do_tick(track(sl, 8 + int'($urandom % 8)), track(sr, 8 + int'($urandom % 8)));
        end

        // right paddle parked away: left wins a full match
        for (int i = 0; i < 6000 && cov_mw_done == 0; i++) begin
            do_tick(track(sl, 12), park(0));
        end

        // left paddle parked away: right scores
        for (int i = 0; i < 1500; i++) begin
            do_tick(park(0), track(sr, 12));
        end

        // random knob bursts
        for (int i = 0; i < 800; i++) begin
            if (($urandom % 4) == 0) do_tick(int'($urandom % 1024), int'($urandom % 1024));
            else do_tick(track(sl, 20), track(sr, 20));
        end

        check(cov_wall > 0, "R4", "wall bounces seen", cov_wall, 1);
        check(cov_hl > 0, "R5", "left hits seen", cov_hl, 1);
        check(cov_hr > 0, "R6", "right hits seen", cov_hr, 1);
        check(cov_bend > 0, "R7", "bent hits seen", cov_bend, 1);
        check(cov_pt_l > 0 && cov_pt_r > 0, "R8", "points both sides", cov_pt_l * 1000 + cov_pt_r, 1001);
        check(cov_pw > 0, "R9", "pause ticks seen", cov_pw, 1);
        check(cov_mw_done > 0, "R10", "match restarts seen", cov_mw_done, 1);

        // R1 again mid-game
        reset_dut();
        do_tick(512, 512);
        finish_run();
    end
endmodule